// File: doc/BRIEF.md
# Multicore Inter-Processor Interrupt and Boot Mailbox Unit

This unit lets any bus master raise interrupts on any core of a 16-core cluster. The cores are arranged as 4 nodes of 4 cores each. Each core owns a 32-bit pending word. A master raises pending bits by writing that core's raise register, which is write-one-to-set. The target core reads its pending word and writes the same value back to its acknowledge register, which is write-one-to-clear. That retires exactly the actions it has seen. Each pending bit is gated by the core's 32-bit mask word. Any surviving bit drives the core's interrupt line, one clock later.

Each core also owns a boot mailbox of four 64-bit words: launch address, stack pointer, global pointer and a spare argument. A booting master fills the spare word first and the launch-address word last. The per-core `launch` output is high whenever the launch-address word is nonzero, which lets a parked secondary core leave its wait loop. Once that core has started, software writes the word back to zero.

The register bus is a plain single-cycle slave. Writes take effect at the clock edge that samples them. Read data appears on the cycle after the read request.

Top module: `ipi_mailbox_unit`

## Requirements
- R1: After a synchronous active-low reset, every pending word, mask word and mailbox word reads zero, and `irq` and `launch` are all low.
- R2: Byte address bits [11:10] give the node and bits [9:8] give the core within the node, so the flat core index is node*4+core. A write to offset 0x08 (raise) ORs the strobed bytes of the write data into that core's pending word. Unstrobed bytes have no effect.
- R3: A write to offset 0x0C (acknowledge) clears exactly the pending bits that are 1 in the strobed bytes of the write data. Writing back a value just read from offset 0x00 leaves the pending word zero.
- R4: Offset 0x04 is the mask word. It is readable and writable. Each write byte strobe updates only its own byte.
- R5: `irq[i]` is a register equal to the OR of (pending AND mask) for core i, taken on the previous cycle. It goes high one cycle after a pending or mask change is visible on the bus, and it goes low one cycle after an acknowledge.
- R6: Writes to offset 0x00 are ignored. Reads of offsets 0x08 and 0x0C return zero. Unmapped offsets, and accesses whose address bits [1:0] are not zero, read zero and change nothing.
- R7: Mailbox word w (0 to 3) of a core sits at offset 0x20+8*w. Its low 32 bits are at +0 and its high 32 bits are at +4. Each half is written under byte strobes and reads back what was written.
- R8: `launch[i]` is high exactly while any bit of mailbox word 0 of core i is nonzero. It follows the write on the cycle after the write edge.
- R9: `bus_rdata` is loaded on the clock edge that samples `bus_rd`. It holds its value on cycles without a read.
- R10: A write to one core changes no register of any other core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write request, sampled at the clock edge |
| bus_rd | input | 1 | Read request, sampled at the clock edge |
| bus_addr | input | 12 | Byte address {node, core, offset} |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Write byte strobes |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 16 | Per-core interrupt line |
| launch | output | 16 | Per-core "launch word is nonzero" flag |

## Verification
Every core is swept with a distinct raise pattern that includes its own index bit, and all 16 pending words are read back after the sweep. A pattern that lands in the wrong core or overwrites instead of ORing shows up as a mismatch. Partial strobes and partial acknowledge masks are run on the set, clear, mask and mailbox paths, which tells byte-merge faults apart from whole-word faults. Interrupt latency is sampled on both sides of the one-cycle register. The mailbox is filled in boot order, and `launch` is checked before and after each half of the launch word is written, which separates "any bit nonzero" from a check on a single half.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the inter-processor interrupt unit.
// Assumes an 8-bit per-core offset field at the bottom of the byte address.
package ipi_pkg;
    localparam int OFF_W = 8;
    localparam logic [OFF_W-1:0] OFF_PEND   = 8'h00;
    localparam logic [OFF_W-1:0] OFF_MASK   = 8'h04;
    localparam logic [OFF_W-1:0] OFF_RAISE  = 8'h08;
    localparam logic [OFF_W-1:0] OFF_ACK    = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_MBOX   = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_MASK,
        SEL_RAISE,
        SEL_ACK,
        SEL_MBOX
    } reg_sel_t;
endpackage

// File: rtl/ipi_addr_decode.sv
`timescale 1ns/1ps
// Splits a byte address into the target core index, the register selected
// and, for the mailbox, the word and half. Assumes the address is
// {node, core, offset}. Unaligned or unmapped offsets select nothing.
module ipi_addr_decode
    import ipi_pkg::*;
#(
    parameter int NODE_BITS = 2,
    parameter int CORE_BITS = 2,
    parameter int MB_WORDS  = 4,
    localparam int IDX_W    = NODE_BITS + CORE_BITS,
    localparam int AW       = IDX_W + OFF_W,
    localparam int WSEL_W   = (MB_WORDS > 1) ? $clog2(MB_WORDS) : 1
) (
    input  logic [AW-1:0]     addr,
    output logic [IDX_W-1:0]  core_idx,
    output reg_sel_t          sel,
    output logic [WSEL_W-1:0] mb_word,
    output logic              mb_hi
);
    localparam logic [OFF_W:0] MB_SPAN = (OFF_W+1)'(8 * MB_WORDS);

    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] rel;

    // Decode the register and the mailbox slot from the offset field.
    always_comb begin
        off      = addr[OFF_W-1:0];
        core_idx = addr[AW-1:OFF_W];
        rel      = off - OFF_MBOX;
        mb_word  = rel[3 +: WSEL_W];
        mb_hi    = rel[2];
        if (off[1:0] != 2'b00)                sel = SEL_NONE;
        else if (off == OFF_PEND)             sel = SEL_PEND;
        else if (off == OFF_MASK)             sel = SEL_MASK;
        else if (off == OFF_RAISE)            sel = SEL_RAISE;
        else if (off == OFF_ACK)              sel = SEL_ACK;
        else if ({1'b0, rel} < MB_SPAN)       sel = SEL_MBOX;
        else                                  sel = SEL_NONE;
    end
endmodule

// File: rtl/ipi_core_slot.sv
`timescale 1ns/1ps
// State of one core: pending word, mask word, boot mailbox, and the
// registered interrupt line. Assumes at most one bus write per cycle.
module ipi_core_slot
    import ipi_pkg::*;
#(
    parameter int DW       = 32,
    parameter int MB_WORDS = 4,
    localparam int SW      = DW / 8,
    localparam int WSEL_W  = (MB_WORDS > 1) ? $clog2(MB_WORDS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  reg_sel_t                         sel,
    input  logic [WSEL_W-1:0]                mb_word,
    input  logic                             mb_hi,
    input  logic [DW-1:0]                    wdata,
    input  logic [SW-1:0]                    wstrb,
    output logic [DW-1:0]                    pend,
    output logic [DW-1:0]                    mask,
    output logic [MB_WORDS-1:0][2*DW-1:0]    mbox,
    output logic                             irq,
    output logic                             launch
);
    logic [DW-1:0] bmask;
    logic [DW-1:0] mdata;

    // Expand byte strobes into a bit mask.
    always_comb begin
        for (int b = 0; b < SW; b++) bmask[b*8 +: 8] = {8{wstrb[b]}};
        mdata = wdata & bmask;
    end

    // Pending word: raise ORs bits in, acknowledge clears bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pend <= '0;
        else if (wr && sel == SEL_RAISE)    pend <= pend | mdata;
        else if (wr && sel == SEL_ACK)      pend <= pend & ~mdata;
    end

    // Mask word: byte-merged write.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mask <= '0;
        else if (wr && sel == SEL_MASK)     mask <= (mask & ~bmask) | mdata;
    end

    for (genvar w = 0; w < MB_WORDS; w++) begin : g_word
        logic hit;
        assign hit = wr && sel == SEL_MBOX && mb_word == WSEL_W'(w);
        // Mailbox word w: byte-merged write of the addressed half.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mbox[w] <= '0;
            else if (hit && mb_hi)
                mbox[w][2*DW-1:DW] <= (mbox[w][2*DW-1:DW] & ~bmask) | mdata;
            else if (hit)
                mbox[w][DW-1:0] <= (mbox[w][DW-1:0] & ~bmask) | mdata;
        end
    end

    // Registered interrupt line from enabled pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(pend & mask);
    end

    assign launch = |mbox[0];
endmodule

// File: rtl/ipi_mailbox_unit.sv
`timescale 1ns/1ps
// Top of the inter-processor interrupt unit: address decode, one state slot
// per core, and the registered read path. Assumes a single-cycle bus slave
// with at most one request (read or write) per cycle.
module ipi_mailbox_unit
    import ipi_pkg::*;
#(
    parameter int NODES          = 4,
    parameter int CORES_PER_NODE = 4,
    parameter int DW             = 32,
    parameter int MB_WORDS       = 4,
    localparam int NCORES        = NODES * CORES_PER_NODE,
    localparam int NODE_BITS     = $clog2(NODES),
    localparam int CORE_BITS     = $clog2(CORES_PER_NODE),
    localparam int IDX_W         = NODE_BITS + CORE_BITS,
    localparam int AW            = IDX_W + OFF_W,
    localparam int SW            = DW / 8,
    localparam int WSEL_W        = (MB_WORDS > 1) ? $clog2(MB_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [SW-1:0]     bus_wstrb,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCORES-1:0] irq,
    output logic [NCORES-1:0] launch
);
    logic [IDX_W-1:0]                                core_idx;
    reg_sel_t                                        sel;
    logic [WSEL_W-1:0]                               mb_word;
    logic                                            mb_hi;
    logic [NCORES-1:0][DW-1:0]                       pend_all;
    logic [NCORES-1:0][DW-1:0]                       mask_all;
    logic [NCORES-1:0][MB_WORDS-1:0][2*DW-1:0]       mbox_all;
    logic [DW-1:0]                                   rd_val;

    ipi_addr_decode #(
        .NODE_BITS (NODE_BITS),
        .CORE_BITS (CORE_BITS),
        .MB_WORDS  (MB_WORDS)
    ) u_dec (
        .addr     (bus_addr),
        .core_idx (core_idx),
        .sel      (sel),
        .mb_word  (mb_word),
        .mb_hi    (mb_hi)
    );

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        ipi_core_slot #(
            .DW       (DW),
            .MB_WORDS (MB_WORDS)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (bus_wr && core_idx == IDX_W'(c)),
            .sel     (sel),
            .mb_word (mb_word),
            .mb_hi   (mb_hi),
            .wdata   (bus_wdata),
            .wstrb   (bus_wstrb),
            .pend    (pend_all[c]),
            .mask    (mask_all[c]),
            .mbox    (mbox_all[c]),
            .irq     (irq[c]),
            .launch  (launch[c])
        );
    end

    // Select the read value of the addressed register.
    always_comb begin
        unique case (sel)
            SEL_PEND: rd_val = pend_all[core_idx];
            SEL_MASK: rd_val = mask_all[core_idx];
            SEL_MBOX: rd_val = mb_hi ? mbox_all[core_idx][mb_word][2*DW-1:DW]
                                     : mbox_all[core_idx][mb_word][DW-1:0];
            default:  rd_val = '0;
        endcase
    end

    // Registered read data, loaded only on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/ipi_mailbox_chk.sv
`timescale 1ns/1ps
// Protocol checker for ipi_mailbox_unit, attached with bind below.
// Assumes the default address layout {node, core, 8-bit offset}.
module ipi_mailbox_chk
    import ipi_pkg::*;
#(
    parameter int NCORES = 16,
    parameter int DW     = 32,
    parameter int AW     = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic [AW-1:0]             bus_addr,
    input logic [DW-1:0]             bus_rdata,
    input logic [NCORES-1:0]         irq,
    input logic [NCORES-1:0]         launch,
    input logic [NCORES-1:0][DW-1:0] pend_all,
    input logic [NCORES-1:0][DW-1:0] mask_all
);
    localparam int IDX_W = AW - OFF_W;

    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] off;
    assign idx = bus_addr[AW-1:OFF_W];
    assign off = bus_addr[OFF_W-1:0];

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq == '0 && launch == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));

    for (genvar i = 0; i < NCORES; i++) begin : g_chk
        // R2
        raise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((pend_all[i] & ~$past(pend_all[i])) != '0)
            |-> $past(bus_wr && idx == IDX_W'(i) && off == OFF_RAISE));

        // R3
        ack_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((~pend_all[i] & $past(pend_all[i])) != '0)
            |-> $past(bus_wr && idx == IDX_W'(i) && off == OFF_ACK));

        // R5
        irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] == $past(|(pend_all[i] & mask_all[i])));

        // R8
        launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (launch[i] != $past(launch[i])) |-> $past(bus_wr && idx == IDX_W'(i)));
    end
endmodule

bind ipi_mailbox_unit ipi_mailbox_chk #(
    .NCORES (NCORES),
    .DW     (DW),
    .AW     (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .launch    (launch),
    .pend_all  (pend_all),
    .mask_all  (mask_all)
);

// File: tb/sim_ipi_mailbox_unit.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every core with computed patterns and
// compares against a model kept in the bench.
module sim_ipi_mailbox_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq;
    logic [15:0] launch;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] exp_pend [16];
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    ipi_mailbox_unit u0 (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_wstrb (bus_wstrb),
        .bus_rdata (bus_rdata), .irq (irq), .launch (launch)
    );

    function automatic logic [11:0] adr(input int c, input logic [7:0] off);
        return {4'(c), off};
    endfunction

    function automatic logic [31:0] pat(input int c);
        return (32'hA500_0000 ^ (32'(c) * 32'h0001_0203)) | (32'h1 << c);
    endfunction

    function automatic logic [31:0] mbv(input int c, input int w, input int h);
        return {8'(c), 8'(w), 8'(h), 8'h5A};
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        for (int c = 0; c < 16; c++) exp_pend[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset
        chk("R1 irq", {16'h0, irq}, 32'h0);
        chk("R1 launch", {16'h0, launch}, 32'h0);
        for (int c = 0; c < 16; c++) begin
            rd(adr(c, 8'h00), rv); chk("R1 pend", rv, 32'h0);
            rd(adr(c, 8'h04), rv); chk("R1 mask", rv, 32'h0);
            for (int k = 0; k < 8; k++) begin
                rd(adr(c, 8'(8'h20 + 4 * k)), rv); chk("R1 mbox", rv, 32'h0);
            end
        end

        // R2 / R10: distinct raise pattern per core, then read all back
        for (int c = 0; c < 16; c++) begin
            wr(adr(c, 8'h08), pat(c), 4'hF);
            exp_pend[c] = exp_pend[c] | pat(c);
        end
        for (int c = 0; c < 16; c++) begin
            rd(adr(c, 8'h00), rv); chk("R2 R10 pend sweep", rv, exp_pend[c]);
        end
        // R2: raise ORs, does not overwrite
        wr(adr(3, 8'h08), 32'h0000_0F00, 4'hF);
        exp_pend[3] = exp_pend[3] | 32'h0000_0F00;
        rd(adr(3, 8'h00), rv); chk("R2 or-in", rv, exp_pend[3]);
        // R2: only strobed bytes raise
        wr(adr(3, 8'h08), 32'hFFFF_FFFF, 4'b0001);
        exp_pend[3] = exp_pend[3] | 32'h0000_00FF;
        rd(adr(3, 8'h00), rv); chk("R2 strobe", rv, exp_pend[3]);
        chk("R5 masked irq", {16'h0, irq}, 32'h0);

        // R3: partial acknowledge clears exactly the ones
        wr(adr(3, 8'h0C), 32'h00F0_0F0F, 4'hF);
        exp_pend[3] = exp_pend[3] & ~32'h00F0_0F0F;
        rd(adr(3, 8'h00), rv); chk("R3 partial ack", rv, exp_pend[3]);
        // R3: write-back of read value acknowledges everything
        rd(adr(7, 8'h00), rv);
        wr(adr(7, 8'h0C), rv, 4'hF);
        exp_pend[7] = '0;
        rd(adr(7, 8'h00), rv); chk("R3 write-back", rv, 32'h0);
        rd(adr(8, 8'h00), rv); chk("R10 neighbour", rv, exp_pend[8]);

        // R5: irq one cycle after mask write
        wr(adr(5, 8'h04), 32'hFFFF_FFFF, 4'hF);
        chk("R5 before", {31'h0, irq[5]}, 32'h0);
        @(negedge clk);
        chk("R5 after", {31'h0, irq[5]}, 32'h1);
        chk("R10 irq others", {16'h0, irq & ~16'h0020}, 32'h0);
        // R4: byte-wise mask update
        wr(adr(6, 8'h04), 32'hFFFF_FFFF, 4'b0010);
        rd(adr(6, 8'h04), rv); chk("R4 mask bytes", rv, 32'h0000_FF00);
        chk("R5 partial mask", {31'h0, irq[6]}, {31'h0, |(exp_pend[6] & 32'h0000_FF00)});
        // R5: irq drops one cycle after acknowledge
        wr(adr(5, 8'h0C), exp_pend[5], 4'hF);
        exp_pend[5] = '0;
        chk("R5 drop before", {31'h0, irq[5]}, 32'h1);
        @(negedge clk);
        chk("R5 drop after", {31'h0, irq[5]}, 32'h0);

        // R6: ignored writes and zero reads
        wr(adr(4, 8'h00), 32'h0, 4'hF);
        rd(adr(4, 8'h00), rv); chk("R6 pend write ignored", rv, exp_pend[4]);
        rd(adr(4, 8'h08), rv); chk("R6 raise reads zero", rv, 32'h0);
        rd(adr(4, 8'h0C), rv); chk("R6 ack reads zero", rv, 32'h0);
        wr(adr(4, 8'h09), 32'hFFFF_FFFF, 4'hF);
        rd(adr(4, 8'h00), rv); chk("R6 unaligned ignored", rv, exp_pend[4]);
        rd(adr(4, 8'h10), rv); chk("R6 unmapped", rv, 32'h0);

        // R7 / R8: boot-order mailbox fill per core
        for (int c = 0; c < 16; c++) begin
            for (int w = 3; w >= 1; w--) begin
                wr(adr(c, 8'(8'h20 + 8 * w + 4)), mbv(c, w, 1), 4'hF);
                wr(adr(c, 8'(8'h20 + 8 * w)), mbv(c, w, 0), 4'hF);
            end
            chk("R8 parked", {31'h0, launch[c]}, 32'h0);
            wr(adr(c, 8'h24), mbv(c, 0, 1), 4'hF);
            chk("R8 high half", {31'h0, launch[c]}, 32'h1);
            wr(adr(c, 8'h20), mbv(c, 0, 0), 4'hF);
        end
        for (int c = 0; c < 16; c++)
            for (int w = 0; w < 4; w++)
                for (int h = 0; h < 2; h++) begin
                    rd(adr(c, 8'(8'h20 + 8 * w + 4 * h)), rv);
                    chk("R7 mbox readback", rv, mbv(c, w, h));
                end
        chk("R8 all launched", {16'h0, launch}, 32'h0000_FFFF);
        // R8: clear launch word half by half
        wr(adr(2, 8'h20), 32'h0, 4'hF);
        chk("R8 one half left", {31'h0, launch[2]}, 32'h1);
        wr(adr(2, 8'h24), 32'h0, 4'hF);
        chk("R8 cleared", {31'h0, launch[2]}, 32'h0);
        chk("R10 launch others", {16'h0, launch}, 32'h0000_FFFB);
        // R7: byte strobe merge in a mailbox half
        wr(adr(9, 8'h28), 32'hFFFF_FFFF, 4'b0100);
        rd(adr(9, 8'h28), rv);
        chk("R7 mbox strobe", rv, mbv(9, 1, 0) | 32'h00FF_0000);

        // R9: read data holds without a read
        rd(adr(3, 8'h00), rv);
        wr(adr(3, 8'h08), 32'h8000_0000, 4'hF);
        repeat (2) @(negedge clk);
        chk("R9 hold", bus_rdata, rv);

        report();
    end
endmodule